// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block produces the port-to-port message interrupts for a memory shared by two ports, called left and right. The two highest word addresses of the array serve as mailboxes. The very top word belongs to the right port and the word below it belongs to the left port. When one port writes into the other port's mailbox, the receiving port's interrupt flag goes low. The flag stays low until its owner reads its own mailbox. The data words stay in the ordinary memory array. This block only watches each port's address and strobes, and it drives the two flags.

Both ports use one common clock. Each port presents an address, a select, a write strobe and a read strobe. If write and read are both high in the same cycle, the access counts as a write. The address width is a parameter: 15 bits for a 32K-word array and 16 bits for a 64K-word array. The mailbox addresses are derived from that width. Every flag is registered and changes one clock after the access that sets or clears it.

Top module: `mbx_irq`

## Requirements
- R1: While `rst` is high at a clock edge, both `l_irq_n` and `r_irq_n` are 1 (deasserted) after that edge.
- R2: A left write (`l_sel`=1, `l_wr`=1) to address all-ones drives `r_irq_n` to 0 after the next clock edge.
- R3: A right write (`r_sel`=1, `r_wr`=1) to address all-ones minus one drives `l_irq_n` to 0 after the next clock edge.
- R4: A right read (`r_sel`=1, `r_rd`=1, `r_wr`=0) of address all-ones drives `r_irq_n` to 1 after the next clock edge, unless R2 sets it in that same cycle.
- R5: A left read (`l_sel`=1, `l_rd`=1, `l_wr`=0) of address all-ones minus one drives `l_irq_n` to 1 after the next clock edge, unless R3 sets it in that same cycle.
- R6: When a set and a clear of the same flag fall in one cycle, the flag ends at 0.
- R7: A port writing its own mailbox, or reading the other port's mailbox, leaves both flags unchanged.
- R8: Any strobe with the port's select at 0 leaves both flags unchanged.
- R9: Accesses to any address below the two mailboxes leave both flags unchanged.
- R10: An access with both `wr` and `rd` at 1 is a write. When the right port does this at its own mailbox, it does not clear `r_irq_n`. When the left port does this at its own mailbox, it does not clear `l_irq_n`.
- R11: A flag that has been set stays at 0 through any number of cycles with no clearing read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock |
| rst | input | 1 | Synchronous reset, active high |
| l_addr | input | ADDR_W | Left port word address |
| l_sel | input | 1 | Left port select, active high |
| l_wr | input | 1 | Left port write strobe |
| l_rd | input | 1 | Left port read strobe |
| r_addr | input | ADDR_W | Right port word address |
| r_sel | input | 1 | Right port select, active high |
| r_wr | input | 1 | Right port write strobe |
| r_rd | input | 1 | Right port read strobe |
| l_irq_n | output | 1 | Left port interrupt flag, active low |
| r_irq_n | output | 1 | Right port interrupt flag, active low |

## Verification
The assertions check the following on every cycle: the reset value, the set caused by a write to the peer's mailbox, the clear caused by the owner's read when no set competes with it, and that a flag keeps its value whenever neither a set nor a clear is decoded. That last check covers the deselected, unrelated-address and wrong-mailbox cases as a group. The bench scenarios show the cases that need a chosen history: a set racing a clear on the same flag, a write-plus-read strobe at the owner's own mailbox, a flag staying set across idle stretches, and reset in the middle of a run with both flags set. A long random run, biased toward the two mailbox words, is compared cycle by cycle against a behavioural model.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;

    localparam int NUM_SIDES = 2;
    localparam int SIDE_L    = 0;
    localparam int SIDE_R    = 1;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    // decoded mailbox events from one port in one cycle
    typedef struct packed {
        logic post;   // write into the peer's mailbox
        logic take;   // read of the port's own mailbox
    } port_evt_t;

    // write wins over read when both strobes are high
    function automatic acc_kind_e classify(input logic sel, input logic wr, input logic rd);
        if (!sel)
            return ACC_IDLE;
        else if (wr)
            return ACC_WRITE;
        else if (rd)
            return ACC_READ;
        else
            return ACC_IDLE;
    endfunction

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_irq_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int SIDE   = SIDE_L
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel,
    input  logic              wr,
    input  logic              rd,
    output port_evt_t         evt
);
    localparam logic [ADDR_W-1:0] TOP_BOX  = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] NEXT_BOX = {{(ADDR_W-1){1'b1}}, 1'b0};
    localparam logic [ADDR_W-1:0] OWN_BOX  = (SIDE == SIDE_R) ? TOP_BOX : NEXT_BOX;
    localparam logic [ADDR_W-1:0] PEER_BOX = (SIDE == SIDE_R) ? NEXT_BOX : TOP_BOX;

    acc_kind_e kind;

    always_comb begin
        kind     = classify(sel, wr, rd);
        evt.post = (kind == ACC_WRITE) && (addr == PEER_BOX);
        evt.take = (kind == ACC_READ)  && (addr == OWN_BOX);
    end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic irq_n
);
    always_ff @(posedge clk) begin
        if (rst)
            irq_n <= 1'b1;
        else if (set)
            irq_n <= 1'b0;   // a set beats a clear
        else if (clr)
            irq_n <= 1'b1;
    end
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq
    import mbx_irq_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_sel,
    input  logic              l_wr,
    input  logic              l_rd,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_sel,
    input  logic              r_wr,
    input  logic              r_rd,
    output logic              l_irq_n,
    output logic              r_irq_n
);
    logic [ADDR_W-1:0] addr_v [NUM_SIDES];
    logic [NUM_SIDES-1:0] sel_v, wr_v, rd_v, irq_v;
    port_evt_t evt_v [NUM_SIDES];

    always_comb begin
        addr_v[SIDE_L] = l_addr;
        addr_v[SIDE_R] = r_addr;
        sel_v = {r_sel, l_sel};
        wr_v  = {r_wr,  l_wr};
        rd_v  = {r_rd,  l_rd};
    end

    for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
        mbx_decode #(.ADDR_W(ADDR_W), .SIDE(g)) u_dec (
            .addr (addr_v[g]),
            .sel  (sel_v[g]),
            .wr   (wr_v[g]),
            .rd   (rd_v[g]),
            .evt  (evt_v[g])
        );
        mbx_flag u_flag (
            .clk   (clk),
            .rst   (rst),
            .set   (evt_v[NUM_SIDES-1-g].post),
            .clr   (evt_v[g].take),
            .irq_n (irq_v[g])
        );
    end

    assign l_irq_n = irq_v[SIDE_L];
    assign r_irq_n = irq_v[SIDE_R];
endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] l_addr,
    input logic              l_sel,
    input logic              l_wr,
    input logic              l_rd,
    input logic [ADDR_W-1:0] r_addr,
    input logic              r_sel,
    input logic              r_wr,
    input logic              r_rd,
    input logic              l_irq_n,
    input logic              r_irq_n
);
    localparam logic [ADDR_W-1:0] HI = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] LO = HI - 1'b1;

    logic set_r, set_l, clr_r, clr_l;
    assign set_r = l_sel && l_wr && (l_addr == HI);
    assign set_l = r_sel && r_wr && (r_addr == LO);
    assign clr_r = r_sel && !r_wr && r_rd && (r_addr == HI);
    assign clr_l = l_sel && !l_wr && l_rd && (l_addr == LO);

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (l_irq_n && r_irq_n)); // R1
    AST_SET_RIGHT: assert property (@(posedge clk) disable iff (rst) set_r |=> !r_irq_n); // R2
    AST_SET_LEFT: assert property (@(posedge clk) disable iff (rst) set_l |=> !l_irq_n); // R3
    AST_CLR_RIGHT: assert property (@(posedge clk) disable iff (rst) (clr_r && !set_r) |=> r_irq_n); // R4
    AST_CLR_LEFT: assert property (@(posedge clk) disable iff (rst) (clr_l && !set_l) |=> l_irq_n); // R5
    AST_HOLD_RIGHT: assert property (@(posedge clk) disable iff (rst) (!set_r && !clr_r) |=> $stable(r_irq_n)); // R7
    AST_HOLD_LEFT: assert property (@(posedge clk) disable iff (rst) (!set_l && !clr_l) |=> $stable(l_irq_n)); // R7
endmodule

bind mbx_irq mbx_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst),
    .l_addr(l_addr), .l_sel(l_sel), .l_wr(l_wr), .l_rd(l_rd),
    .r_addr(r_addr), .r_sel(r_sel), .r_wr(r_wr), .r_rd(r_rd),
    .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
);

// File: tb/mbx_irq_tb.sv
`timescale 1ns/1ps
module mbx_irq_tb;
    localparam int AW = 15;
    localparam logic [AW-1:0] HI = {AW{1'b1}};
    localparam logic [AW-1:0] LO = HI - 1'b1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic l_sel = 0, l_wr = 0, l_rd = 0, r_sel = 0, r_wr = 0, r_rd = 0;
    logic l_irq_n, r_irq_n;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";
    bit exp_l = 1'b1, exp_r = 1'b1;
    bit done = 0;

    always #4 clk = ~clk;

    mbx_irq #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst),
        .l_addr(l_addr), .l_sel(l_sel), .l_wr(l_wr), .l_rd(l_rd),
        .r_addr(r_addr), .r_sel(r_sel), .r_wr(r_wr), .r_rd(r_rd),
        .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
    );

    // behavioural reference: a mailbox is pending while its owner has unread mail
    always @(posedge clk) begin
        bit l_is_write, r_is_write;
        bit mail_r, mail_l, read_r, read_l;
        l_is_write = l_sel && l_wr;
        r_is_write = r_sel && r_wr;
        mail_r = l_is_write && (l_addr == HI);
        mail_l = r_is_write && (r_addr == LO);
        read_r = r_sel && r_rd && !r_wr && (r_addr == HI);
        read_l = l_sel && l_rd && !l_wr && (l_addr == LO);
        if (rst) begin
            exp_l <= 1'b1;
            exp_r <= 1'b1;
        end else begin
            if (mail_l) exp_l <= 1'b0; else if (read_l) exp_l <= 1'b1;
            if (mail_r) exp_r <= 1'b0; else if (read_r) exp_r <= 1'b1;
        end
    end

    // compare against the model on every cycle, away from the edge
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (l_irq_n !== exp_l || r_irq_n !== exp_r) begin
                failures++;
                $display("FAIL %s model compare: l_irq_n=%b r_irq_n=%b expected %b %b",
                         cur_req, l_irq_n, r_irq_n, exp_l, exp_r);
            end
        end
    end

    task automatic check(input string req, input logic got_l, input logic got_r,
                         input logic want_l, input logic want_r);
        checks++;
        if (got_l !== want_l || got_r !== want_r) begin
            failures++;
            $display("FAIL %s: l_irq_n=%b r_irq_n=%b expected %b %b",
                     req, got_l, got_r, want_l, want_r);
        end
    endtask

    // drive one cycle of access at a falling edge, return at the next falling edge
    task automatic cyc(input logic ls, input logic lw, input logic lr, input logic [AW-1:0] la,
                       input logic rs, input logic rw, input logic rr, input logic [AW-1:0] ra);
        l_sel = ls; l_wr = lw; l_rd = lr; l_addr = la;
        r_sel = rs; r_wr = rw; r_rd = rr; r_addr = ra;
        @(posedge clk);
        @(negedge clk);
        l_sel = 0; l_wr = 0; l_rd = 0; r_sel = 0; r_wr = 0; r_rd = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, '0, 0, 0, 0, '0);
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R1", l_irq_n, r_irq_n, 1, 1);
        rst = 0;
        idle(1);

        cur_req = "R2";
        cyc(1, 1, 0, HI, 0, 0, 0, '0);
        check("R2", l_irq_n, r_irq_n, 1, 0);

        cur_req = "R7";
        cyc(1, 1, 0, LO, 0, 0, 0, '0);   // left writes its own box
        check("R7", l_irq_n, r_irq_n, 1, 0);
        cyc(0, 0, 0, '0, 1, 0, 1, LO);   // right reads left's box
        check("R7", l_irq_n, r_irq_n, 1, 0);

        cur_req = "R9";
        cyc(1, 0, 1, 15'h1234, 1, 0, 1, 15'h7FFD);
        check("R9", l_irq_n, r_irq_n, 1, 0);
        cur_req = "R8";
        cyc(0, 0, 1, LO, 0, 0, 1, HI);   // deselected clearing reads
        check("R8", l_irq_n, r_irq_n, 1, 0);

        cur_req = "R11";
        idle(20);
        check("R11", l_irq_n, r_irq_n, 1, 0);

        cur_req = "R10";
        cyc(0, 0, 0, '0, 1, 1, 1, HI);   // write+read at own box counts as write
        check("R10", l_irq_n, r_irq_n, 1, 0);

        cur_req = "R4";
        cyc(0, 0, 0, '0, 1, 0, 1, HI);
        check("R4", l_irq_n, r_irq_n, 1, 1);

        cur_req = "R3";
        cyc(0, 0, 0, '0, 1, 1, 0, LO);
        check("R3", l_irq_n, r_irq_n, 0, 1);
        cur_req = "R8";
        cyc(0, 1, 0, HI, 0, 1, 0, '0);   // deselected write to right box
        check("R8", l_irq_n, r_irq_n, 0, 1);
        cur_req = "R10";
        cyc(1, 1, 1, LO, 0, 0, 0, '0);
        check("R10", l_irq_n, r_irq_n, 0, 1);

        cur_req = "R5";
        cyc(1, 0, 1, LO, 0, 0, 0, '0);
        check("R5", l_irq_n, r_irq_n, 1, 1);

        cur_req = "R6";
        cyc(1, 0, 1, LO, 1, 1, 0, LO);   // left clear races right set
        check("R6", l_irq_n, r_irq_n, 0, 1);
        cyc(1, 1, 0, HI, 1, 0, 1, HI);   // right clear races left set
        check("R6", l_irq_n, r_irq_n, 0, 0);

        cur_req = "R1";
        rst = 1;
        idle(1);
        check("R1", l_irq_n, r_irq_n, 1, 1);
        rst = 0;

        cur_req = "random";
        for (int i = 0; i < 3000; i++) begin
            logic [AW-1:0] la, ra;
            int pick;
            pick = $urandom_range(0, 3);
            la = (pick == 0) ? HI : (pick == 1) ? LO : AW'($urandom);
            pick = $urandom_range(0, 3);
            ra = (pick == 0) ? HI : (pick == 1) ? LO : AW'($urandom);
            cyc($urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1, la,
                $urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1, ra);
        end

        finish_run();
    end
endmodule